// File: doc/BRIEF.md
# Request Packet Receive Checker

This block sits on the receive side of a packet-based serial link, above the layer that already handles per-hop integrity. Request packets arrive as a stream of 32-bit words, framed by a start marker on the first word and an end marker on the last. The block reads the leading format code to learn how long the header is and whether a data section follows. It collects the header fields and the payload, and checks the packet's structure against its own length field. When the packet carries an end-to-end CRC word at its tail, the block recomputes the CRC and compares the two.

A packet that passes every check is handed to the local function. The decoded header appears with a one-cycle strobe, and the payload follows as a burst with the header and the CRC word removed. The payload is held in a one-packet buffer until the end marker and the CRC verdict are known, so a bad packet never reaches the local side, not even in part. A failing packet produces exactly one of three error pulses: malformed, unsupported request or digest mismatch. Nothing is retried.

Top module: `rx_req_checker`

## Requirements
- R1: Header word 0 is decoded as follows. Bits [31:29] are the format code: bit 29 set means a four-word header, bit 30 set means a data section follows, and bit 31 is reserved. Bits [28:24] are the type. Bit 15 marks a CRC word at the tail. Bits [9:0] give the length in words, where 0 stands for 1024. Word 1 holds the requester id in [31:16], the tag in [15:8], the last-word byte enables in [7:4] and the first-word byte enables in [3:0]. Word 2 holds the address bits [31:2] for a three-word header, or the upper 32 address bits for a four-word header. In the four-word case, word 3 holds the address bits [31:2].
- R2: A good memory write (type 0, format x1x) raises hdr_valid for exactly one cycle, in the cycle after its end word is accepted. In that cycle hdr_is_write is 1, hdr_addr carries the address with bits [1:0] zero (upper half zero for three-word headers), and hdr_len, hdr_req_id, hdr_tag and both byte-enable fields are valid.
- R3: The payload of a good write is delivered on pay_data, one word per cycle and in arrival order, starting in the same cycle as hdr_valid. pay_last is set on the final word. The header and the CRC word are never delivered.
- R4: The tail CRC is CRC-32 with polynomial 0x04C11DB7 and seed 0xFFFFFFFF, computed over all preceding words of the packet, bit 31 of each word first, and inverted at the end. On a mismatch err_digest pulses for one cycle and neither hdr_valid nor any payload word appears.
- R5: A packet whose accepted word count differs from header size + length (when data is present) + 1 (when bit 15 is set) is malformed. This covers a short or long payload, a missing or extra CRC word, and an end marker inside the header.
- R6: A write whose length exceeds MAX_PAYLOAD_DW is malformed.
- R7: A format code with bit 31 set is malformed.
- R8: Any type other than 0 is an unsupported request. The verdicts are ranked malformed first, then unsupported, then digest. Every packet ends in exactly one of hdr_valid, err_malformed, err_unsupported or err_digest, one cycle after its end word.
- R9: A good memory read (format x0x) gives hdr_valid with hdr_is_write 0 and its length field decoded per R1. No payload words are delivered for it.
- R10: in_ready is low for exactly hdr_len cycles while a good write's payload is released, and high at all other times. Words offered with in_valid while no packet is open and without in_sop are ignored.
- R11: After reset all strobes and error pulses are low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Input word present |
| in_sop | input | 1 | First word of a packet |
| in_eop | input | 1 | Last word of a packet |
| in_data | input | 32 | Input word |
| in_ready | output | 1 | Block can accept a word |
| hdr_valid | output | 1 | Good packet decoded (one-cycle strobe) |
| hdr_is_write | output | 1 | Packet carried data |
| hdr_addr | output | 64 | Decoded byte address |
| hdr_len | output | 11 | Length in words (1 to 1024) |
| hdr_req_id | output | 16 | Requester id |
| hdr_tag | output | 8 | Tag |
| hdr_first_be | output | 4 | First-word byte enables |
| hdr_last_be | output | 4 | Last-word byte enables |
| pay_valid | output | 1 | Payload word valid |
| pay_data | output | 32 | Payload word |
| pay_last | output | 1 | Final payload word |
| err_malformed | output | 1 | Structural error pulse |
| err_unsupported | output | 1 | Unsupported request pulse |
| err_digest | output | 1 | CRC mismatch pulse |

## Verification
The hardest case to reach from the ports is a packet that is correct in every respect except one CRC bit, because both the word count and the CRC-flag bit have to agree exactly for the digest comparison to decide the verdict. The same holds for the ranking between verdicts when two faults coincide. The stimulus builds whole packets in the bench, including a reference CRC, and then injects exactly one controlled fault: a flipped CRC bit, a missing or extra word, an oversized length, a reserved format or a foreign type. It adds a few packets that carry two faults, to exercise the ranking, and mixes these with randomly shaped packets. These include writes of exactly MAX_PAYLOAD_DW words and a read whose length field is 0. Every packet waits for in_ready, so the release window is exercised back to back.

// File: rtl/rxchk_pkg.sv
package rxchk_pkg;

  localparam int WORD_W = 32;
  localparam int LEN_W  = 11;
  localparam logic [WORD_W-1:0] CRC_POLY = 32'h04C1_1DB7;
  localparam logic [WORD_W-1:0] CRC_SEED = 32'hFFFF_FFFF;

  typedef struct packed {
    logic             reserved;
    logic             has_data;
    logic             four_dw;
    logic             is_mem;
    logic             digest;
    logic [LEN_W-1:0] len_dw;
  } hdr0_t;

  typedef enum logic [1:0] {
    V_GOOD      = 2'd0,
    V_MALFORMED = 2'd1,
    V_UNSUP     = 2'd2,
    V_DIGEST    = 2'd3
  } verdict_e;

  // Decode the leading header word into the fields that steer the packet.
  function automatic hdr0_t decode_dw0(logic [WORD_W-1:0] w);
    hdr0_t d;
    d.reserved = w[31];
    d.has_data = w[30];
    d.four_dw  = w[29];
    d.is_mem   = (w[28:24] == 5'd0);
    d.digest   = w[15];
    d.len_dw   = (w[9:0] == 10'd0) ? 11'd1024 : {1'b0, w[9:0]};
    return d;
  endfunction

  // Total words a well-formed packet with this leading word must carry.
  function automatic logic [12:0] expected_words(hdr0_t d);
    logic [12:0] n;
    n = d.four_dw ? 13'd4 : 13'd3;
    if (d.has_data) n = n + {2'b00, d.len_dw};
    if (d.digest)   n = n + 13'd1;
    return n;
  endfunction

  // One 32-bit CRC step, most significant bit of the word first.
  function automatic logic [WORD_W-1:0] crc_step(logic [WORD_W-1:0] c,
                                                 logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] r;
    logic fb;
    r = c;
    for (int i = WORD_W - 1; i >= 0; i--) begin
      fb = r[WORD_W-1] ^ w[i];
      r  = {r[WORD_W-2:0], 1'b0};
      if (fb) r = r ^ CRC_POLY;
    end
    return r;
  endfunction

endpackage

// File: rtl/rxchk_crc.sv
module rxchk_crc
  import rxchk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic              restart,
  input  logic [WORD_W-1:0] word,
  output logic [WORD_W-1:0] digest_expect
);

  logic [WORD_W-1:0] crc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= CRC_SEED;
    end else if (step_en) begin
      crc_q <= crc_step(restart ? CRC_SEED : crc_q, word);
    end
  end

  // The CRC word expected at the current position, covering every earlier word.
  assign digest_expect = ~crc_q;

endmodule

// File: rtl/rxchk_pbuf.sv
module rxchk_pbuf
  import rxchk_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [WORD_W-1:0] rd_data
);

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/rxchk_verdict.sv
module rxchk_verdict
  import rxchk_pkg::*;
#(
  parameter int MAX_PAYLOAD_DW = 32
) (
  input  hdr0_t             hdr,
  input  logic [12:0]       total,
  input  logic [WORD_W-1:0] last_word,
  input  logic [WORD_W-1:0] digest_expect,
  output verdict_e          verdict
);

  logic oversize, count_bad, malformed, digest_bad;

  always_comb begin
    oversize   = hdr.has_data && (hdr.len_dw > LEN_W'(MAX_PAYLOAD_DW));
    count_bad  = (total != expected_words(hdr));
    malformed  = hdr.reserved || oversize || count_bad;
    digest_bad = hdr.digest && (last_word != digest_expect);
    if (malformed)        verdict = V_MALFORMED;
    else if (!hdr.is_mem) verdict = V_UNSUP;
    else if (digest_bad)  verdict = V_DIGEST;
    else                  verdict = V_GOOD;
  end

endmodule

// File: rtl/rx_req_checker.sv
module rx_req_checker
  import rxchk_pkg::*;
#(
  parameter int MAX_PAYLOAD_DW = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic        in_sop,
  input  logic        in_eop,
  input  logic [31:0] in_data,
  output logic        in_ready,
  output logic        hdr_valid,
  output logic        hdr_is_write,
  output logic [63:0] hdr_addr,
  output logic [10:0] hdr_len,
  output logic [15:0] hdr_req_id,
  output logic [7:0]  hdr_tag,
  output logic [3:0]  hdr_first_be,
  output logic [3:0]  hdr_last_be,
  output logic        pay_valid,
  output logic [31:0] pay_data,
  output logic        pay_last,
  output logic        err_malformed,
  output logic        err_unsupported,
  output logic        err_digest
);

  localparam int AW = (MAX_PAYLOAD_DW > 1) ? $clog2(MAX_PAYLOAD_DW) : 1;
  localparam int CW = 12;
  localparam logic [CW-1:0] CNT_SAT = '1;

  // Packet position tracking
  logic          in_pkt_q;
  logic [CW-1:0] cnt_q;
  logic          acc, take, pkt_end;
  logic [CW-1:0] idx, hdr_words, pay_off;
  logic [12:0]   total;

  // Captured header words
  logic [WORD_W-1:0] dw0_q, dw1_q, dw2_q;
  logic [29:0]       dw3_q;
  logic [WORD_W-1:0] dw0_c, dw1_c, dw2_c;
  logic [29:0]       dw3_c;
  hdr0_t             hdr;

  // Check and release
  logic [WORD_W-1:0] digest_expect;
  verdict_e          verdict;
  logic              pkt_good, wr_en;
  logic              drain_q;
  logic [AW-1:0]     rd_q;
  logic [LEN_W-1:0]  drain_len_q;
  logic              drain_end;

  assign in_ready = !drain_q;
  assign acc      = in_valid && in_ready;
  assign take     = acc && (in_sop || in_pkt_q);
  assign pkt_end  = take && in_eop;
  assign idx      = in_sop ? '0 : cnt_q;
  assign total    = {1'b0, idx} + 13'd1;

  // Words still arriving this cycle are taken straight from the input.
  assign dw0_c = (idx == CW'(0)) ? in_data : dw0_q;
  assign dw1_c = (idx == CW'(1)) ? in_data : dw1_q;
  assign dw2_c = (idx == CW'(2)) ? in_data : dw2_q;
  assign dw3_c = (idx == CW'(3)) ? in_data[31:2] : dw3_q;
  assign hdr   = decode_dw0(dw0_c);

  assign hdr_words = hdr.four_dw ? CW'(4) : CW'(3);
  assign pay_off   = idx - hdr_words;
  assign wr_en     = take && hdr.has_data && (idx >= hdr_words) &&
                     (pay_off < CW'(MAX_PAYLOAD_DW));

  rxchk_crc u_crc (
    .clk           (clk),
    .rst_n         (rst_n),
    .step_en       (take),
    .restart       (in_sop),
    .word          (in_data),
    .digest_expect (digest_expect)
  );

  rxchk_verdict #(.MAX_PAYLOAD_DW(MAX_PAYLOAD_DW)) u_verdict (
    .hdr           (hdr),
    .total         (total),
    .last_word     (in_data),
    .digest_expect (digest_expect),
    .verdict       (verdict)
  );

  rxchk_pbuf #(.DEPTH(MAX_PAYLOAD_DW)) u_pbuf (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (pay_off[AW-1:0]),
    .wr_data (in_data),
    .rd_addr (rd_q),
    .rd_data (pay_data)
  );

  assign pkt_good = pkt_end && (verdict == V_GOOD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_pkt_q <= 1'b0;
      cnt_q    <= '0;
      dw0_q    <= '0;
      dw1_q    <= '0;
      dw2_q    <= '0;
      dw3_q    <= '0;
    end else if (take) begin
      in_pkt_q <= !in_eop;
      cnt_q    <= in_eop ? '0 : ((idx == CNT_SAT) ? CNT_SAT : idx + CW'(1));
      dw0_q    <= dw0_c;
      dw1_q    <= dw1_c;
      dw2_q    <= dw2_c;
      dw3_q    <= dw3_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr_valid       <= 1'b0;
      err_malformed   <= 1'b0;
      err_unsupported <= 1'b0;
      err_digest      <= 1'b0;
      hdr_is_write    <= 1'b0;
      hdr_addr        <= '0;
      hdr_len         <= '0;
      hdr_req_id      <= '0;
      hdr_tag         <= '0;
      hdr_first_be    <= '0;
      hdr_last_be     <= '0;
    end else begin
      hdr_valid       <= pkt_good;
      err_malformed   <= pkt_end && (verdict == V_MALFORMED);
      err_unsupported <= pkt_end && (verdict == V_UNSUP);
      err_digest      <= pkt_end && (verdict == V_DIGEST);
      if (pkt_good) begin
        hdr_is_write <= hdr.has_data;
        hdr_addr     <= hdr.four_dw ? {dw2_c, dw3_c, 2'b00}
                                    : {32'd0, dw2_c[31:2], 2'b00};
        hdr_len      <= hdr.len_dw;
        hdr_req_id   <= dw1_c[31:16];
        hdr_tag      <= dw1_c[15:8];
        hdr_last_be  <= dw1_c[7:4];
        hdr_first_be <= dw1_c[3:0];
      end
    end
  end

  assign drain_end = drain_q && (LEN_W'(rd_q) == drain_len_q - LEN_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drain_q     <= 1'b0;
      rd_q        <= '0;
      drain_len_q <= '0;
    end else if (drain_q) begin
      if (drain_end) drain_q <= 1'b0;
      else           rd_q    <= rd_q + AW'(1);
    end else if (pkt_good && hdr.has_data) begin
      drain_q     <= 1'b1;
      rd_q        <= '0;
      drain_len_q <= hdr.len_dw;
    end
  end

  assign pay_valid = drain_q;
  assign pay_last  = drain_end;

endmodule

// File: rtl/rx_req_checker_props.sv
module rx_req_checker_props (
  input logic clk,
  input logic rst_n,
  input logic in_ready,
  input logic hdr_valid,
  input logic hdr_is_write,
  input logic pay_valid,
  input logic pay_last,
  input logic err_malformed,
  input logic err_unsupported,
  input logic err_digest,
  input logic pkt_end
);

  logic any_err;
  assign any_err = err_malformed || err_unsupported || err_digest;

  a_r8_single_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hdr_valid, err_malformed, err_unsupported, err_digest}));

  a_r8_every_packet_resolved: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_end |=> ($countones({hdr_valid, err_malformed, err_unsupported, err_digest}) == 1));

  a_r4_no_release_on_error: assert property (@(posedge clk) disable iff (!rst_n)
    any_err |-> !pay_valid);

  a_r3_release_with_header: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pay_valid) |-> (hdr_valid && hdr_is_write));

  a_r3_last_closes_burst: assert property (@(posedge clk) disable iff (!rst_n)
    (pay_valid && pay_last) |=> !pay_valid);

  a_r10_ready_low_in_release: assert property (@(posedge clk) disable iff (!rst_n)
    pay_valid |-> !in_ready);

  a_r9_read_has_no_payload: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && !hdr_is_write) |-> !pay_valid);

  a_r2_header_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid |=> !hdr_valid);

endmodule

bind rx_req_checker rx_req_checker_props u_props (
  .clk             (clk),
  .rst_n           (rst_n),
  .in_ready        (in_ready),
  .hdr_valid       (hdr_valid),
  .hdr_is_write    (hdr_is_write),
  .pay_valid       (pay_valid),
  .pay_last        (pay_last),
  .err_malformed   (err_malformed),
  .err_unsupported (err_unsupported),
  .err_digest      (err_digest),
  .pkt_end         (pkt_end)
);

// File: tb/rx_req_checker_test.sv
module rx_req_checker_test;

  localparam int CLK_PERIOD = 10;
  localparam int MAXP = 32;
  localparam logic [31:0] POLY = 32'h04C1_1DB7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_ready, hdr_valid, hdr_is_write, pay_valid, pay_last;
  logic [63:0] hdr_addr;
  logic [10:0] hdr_len;
  logic [15:0] hdr_req_id;
  logic [7:0]  hdr_tag;
  logic [3:0]  hdr_first_be, hdr_last_be;
  logic [31:0] pay_data;
  logic        err_malformed, err_unsupported, err_digest;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_req_checker #(.MAX_PAYLOAD_DW(MAXP)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
    .in_data(in_data), .in_ready(in_ready), .hdr_valid(hdr_valid),
    .hdr_is_write(hdr_is_write), .hdr_addr(hdr_addr), .hdr_len(hdr_len),
    .hdr_req_id(hdr_req_id), .hdr_tag(hdr_tag), .hdr_first_be(hdr_first_be),
    .hdr_last_be(hdr_last_be), .pay_valid(pay_valid), .pay_data(pay_data),
    .pay_last(pay_last), .err_malformed(err_malformed),
    .err_unsupported(err_unsupported), .err_digest(err_digest)
  );

  int checks = 0;
  int errors = 0;

  // Monitor: cumulative counts, sampled at the falling edge
  int          m_hdr = 0, m_mal = 0, m_ur = 0, m_dig = 0, m_stall = 0, m_n = 0;
  int          m_last_idx = -1, m_lasts = 0;
  logic        m_wr;
  logic [63:0] m_addr;
  logic [10:0] m_len;
  logic [15:0] m_rid;
  logic [7:0]  m_tag;
  logic [3:0]  m_fbe, m_lbe;
  logic [31:0] m_pay [8192];

  always @(negedge clk) begin
    if (rst_n) begin
      if (hdr_valid) begin
        m_hdr++; m_wr = hdr_is_write; m_addr = hdr_addr; m_len = hdr_len;
        m_rid = hdr_req_id; m_tag = hdr_tag; m_fbe = hdr_first_be; m_lbe = hdr_last_be;
      end
      if (err_malformed)   m_mal++;
      if (err_unsupported) m_ur++;
      if (err_digest)      m_dig++;
      if (!in_ready)       m_stall++;
      if (pay_valid) begin
        if (m_n < 8192) m_pay[m_n] = pay_data;
        if (pay_last) begin m_last_idx = m_n; m_lasts++; end
        m_n++;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Packet under construction
  logic [31:0] pkt [2048];
  int          pkt_n;
  logic [31:0] exp_pay [2048];

  function automatic logic [31:0] ref_crc(input int n);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int k = 0; k < n; k++) begin
      c = c ^ pkt[k];
      for (int b = 0; b < 32; b++) c = c[31] ? ((c << 1) ^ POLY) : (c << 1);
    end
    return ~c;
  endfunction

  // 0 good, 1 malformed, 2 unsupported, 3 digest
  function automatic int exp_kind(input logic [2:0] fmt, input logic [4:0] typ,
                                  input bit td, input logic [9:0] len,
                                  input int pay_n, input bit dig_on, input bit flip);
    int hw = fmt[0] ? 4 : 3;
    int ld = (len == 0) ? 1024 : int'(len);
    int want = hw + (fmt[1] ? ld : 0) + (td ? 1 : 0);
    int got  = hw + pay_n + (dig_on ? 1 : 0);
    if (fmt[2]) return 1;
    if (fmt[1] && ld > MAXP) return 1;
    if (got != want) return 1;
    if (typ != 0) return 2;
    if (td && flip) return 3;
    return 0;
  endfunction

  task automatic send_words(input int n, input int trunc);
    int cnt = (trunc > 0) ? trunc : n;
    for (int i = 0; i < cnt; i++) begin
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1; in_sop = (i == 0); in_eop = (i == cnt - 1); in_data = pkt[i];
    end
    @(negedge clk);
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
  endtask

  task automatic run_case(input logic [2:0] fmt, input logic [4:0] typ, input bit td,
                          input logic [9:0] len, input int pay_n, input bit dig_on,
                          input bit flip, input int trunc, input int kind_force);
    logic [63:0] addr = {$urandom, $urandom};
    logic [15:0] rid = 16'($urandom);
    logic [7:0]  tg = 8'($urandom);
    logic [3:0]  fb = 4'($urandom), lb = 4'($urandom);
    int hw = fmt[0] ? 4 : 3;
    int ld = (len == 0) ? 1024 : int'(len);
    int kind, b_hdr, b_mal, b_ur, b_dig, b_st, b_n, b_lasts;
    logic [63:0] eaddr;
    string tg_s;
    pkt[0] = {fmt, typ, 8'h00, td, 5'h00, len};
    pkt[1] = {rid, tg, lb, fb};
    if (fmt[0]) begin pkt[2] = addr[63:32]; pkt[3] = {addr[31:2], 2'b00}; end
    else        pkt[2] = {addr[31:2], 2'b00};
    for (int i = 0; i < pay_n; i++) begin
      exp_pay[i] = $urandom;
      pkt[hw + i] = exp_pay[i];
    end
    pkt_n = hw + pay_n;
    if (dig_on) begin
      pkt[pkt_n] = ref_crc(pkt_n) ^ (flip ? (32'd1 << ($urandom % 32)) : 32'd0);
      pkt_n++;
    end
    kind = (kind_force >= 0) ? kind_force : exp_kind(fmt, typ, td, len, pay_n, dig_on, flip);
    eaddr = fmt[0] ? {addr[63:2], 2'b00} : {32'd0, addr[31:2], 2'b00};
    @(posedge clk);
    b_hdr = m_hdr; b_mal = m_mal; b_ur = m_ur; b_dig = m_dig; b_st = m_stall;
    b_n = m_n; b_lasts = m_lasts;
    send_words(pkt_n, trunc);
    repeat (pay_n + 8) @(negedge clk);
    @(posedge clk);
    tg_s = (kind == 1) ? "R5" : (kind == 2) ? "R8" : (kind == 3) ? "R4" : "R2";
    check(m_hdr - b_hdr == (kind == 0 ? 1 : 0), tg_s, "header strobes", m_hdr - b_hdr, kind == 0);
    check(m_mal - b_mal == (kind == 1 ? 1 : 0), tg_s, "malformed pulses", m_mal - b_mal, kind == 1);
    check(m_ur - b_ur == (kind == 2 ? 1 : 0), tg_s, "unsupported pulses", m_ur - b_ur, kind == 2);
    check(m_dig - b_dig == (kind == 3 ? 1 : 0), tg_s, "digest pulses", m_dig - b_dig, kind == 3);
    if (kind == 0) begin
      check(m_wr == fmt[1], "R2", "is_write", m_wr, fmt[1]);
      check(m_addr == eaddr, "R2", "address", m_addr, eaddr);
      check(m_len == 11'(ld), "R1", "length", m_len, ld);
      check({m_rid, m_tag, m_lbe, m_fbe} == {rid, tg, lb, fb}, "R2", "id/tag/be",
            {m_rid, m_tag, m_lbe, m_fbe}, {rid, tg, lb, fb});
      if (fmt[1]) begin
        check(m_n - b_n == ld, "R3", "payload words", m_n - b_n, ld);
        for (int i = 0; i < ld && i < pay_n; i++)
          if (m_pay[b_n + i] != exp_pay[i])
            check(0, "R3", "payload data", m_pay[b_n + i], exp_pay[i]);
        check(m_lasts - b_lasts == 1 && m_last_idx == b_n + ld - 1, "R3", "last position",
              m_last_idx - b_n, ld - 1);
        check(m_stall - b_st == ld, "R10", "ready low cycles", m_stall - b_st, ld);
      end else begin
        check(m_n == b_n, "R9", "read payload words", m_n - b_n, 0);
        check(m_stall == b_st, "R10", "ready low on read", m_stall - b_st, 0);
      end
    end else begin
      check(m_n == b_n, "R4", "payload after error", m_n - b_n, 0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R11: reset state
    check(!hdr_valid && !pay_valid && !err_malformed && !err_unsupported && !err_digest,
          "R11", "strobes in reset", {hdr_valid, pay_valid, err_malformed}, 0);
    check(in_ready == 1'b1, "R11", "ready in reset", in_ready, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!hdr_valid && !pay_valid && in_ready, "R11", "after reset",
          {hdr_valid, pay_valid, in_ready}, 1);

    // R10: stray words outside a packet are ignored
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); in_valid = 1'b1; in_sop = 1'b0; in_eop = (i == 3); in_data = $urandom;
    end
    @(negedge clk); in_valid = 1'b0; in_eop = 1'b0;
    repeat (4) @(negedge clk);
    @(posedge clk);
    check(m_hdr + m_mal + m_ur + m_dig == 0 && m_n == 0, "R10", "stray words ignored",
          m_hdr + m_mal + m_ur + m_dig + m_n, 0);

    run_case(3'b010, 5'd0, 1'b1, 10'd4, 4, 1'b1, 1'b0, 0, -1);        // R2 R3 R4 good write
    run_case(3'b011, 5'd0, 1'b0, 10'(MAXP), MAXP, 1'b0, 1'b0, 0, -1); // R6 boundary
    run_case(3'b010, 5'd0, 1'b0, 10'(MAXP + 1), MAXP + 1, 1'b0, 1'b0, 0, 1); // R6
    run_case(3'b100, 5'd0, 1'b0, 10'd1, 0, 1'b0, 1'b0, 0, 1);         // R7 reserved format
    run_case(3'b000, 5'd4, 1'b0, 10'd1, 0, 1'b0, 1'b0, 0, 2);         // R8 unsupported
    run_case(3'b010, 5'd0, 1'b1, 10'd3, 3, 1'b1, 1'b1, 0, 3);         // R4 digest flip
    run_case(3'b010, 5'd0, 1'b1, 10'd3, 3, 1'b0, 1'b0, 0, 1);         // R5 missing digest
    run_case(3'b011, 5'd0, 1'b0, 10'd5, 4, 1'b0, 1'b0, 0, 1);         // R5 short payload
    run_case(3'b000, 5'd0, 1'b0, 10'd1, 0, 1'b0, 1'b0, 1, 1);         // R5 end in header
    run_case(3'b001, 5'd0, 1'b1, 10'd0, 0, 1'b1, 1'b0, 0, -1);        // R9 R1 length 1024
    run_case(3'b010, 5'd2, 1'b0, 10'd2, 3, 1'b0, 1'b0, 0, 1);         // R8 priority
    run_case(3'b000, 5'd0, 1'b0, 10'd7, 0, 1'b0, 1'b0, 0, -1);        // R9 read

    for (int n = 0; n < 80; n++) begin
      logic [2:0] f = ($urandom % 10 == 0) ? 3'(4 + $urandom % 4) : 3'($urandom % 4);
      logic [4:0] t = ($urandom % 6 == 0) ? 5'(1 + $urandom % 31) : 5'd0;
      bit td = $urandom % 2;
      logic [9:0] ln = 10'(1 + $urandom % (MAXP + 1));
      int pn = f[1] ? int'(ln) : 0;
      bit don = td;
      int r = $urandom % 8;
      if (r == 0) pn = pn + 1;
      if (r == 1 && pn > 0) pn = pn - 1;
      if (r == 2) don = !td;
      if (f[1] && pn > MAXP + 2) pn = MAXP + 2;
      run_case(f, t, td, ln, pn, don, (r == 3), 0, -1);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule